// File: doc/BRIEF.md
# Streaming K-Way Merge Tree

This block merges several independently sorted runs of unsigned keys into one sorted stream. Each of the `WAYS` leaf inputs feeds a FIFO that collects one ascending run, and the writer marks the run's last key with an end flag. A binary tree of `WAYS-1` two-input merge cells, `log2(WAYS)` levels deep, sits above the leaves. Each cell compares the heads of its two children and moves the smaller key into a small buffer of its own. That buffer is the head its parent sees.

A cell moves a key only when it knows the choice is safe. Either both children hold a key of the current run, or one child has already delivered the final key of its run. An empty slot is never treated as a key. Ties go to the left child. The root buffer drives a valid/ready output. Its `last` flag marks the final key of the merged set, which holds one run from every leaf. Keys written into a leaf after its end marker wait there for the next merge. The block is used between a run-forming stage and a store stage in a multi-pass external sort, and each pass multiplies the run length by `WAYS`.

Top module: `mst_tree`

## Requirements
- R1: Directly after reset `out_valid` is 0 and every bit of `in_ready` is 1.
- R2: Within one merged set the output keys are non-decreasing, compared as unsigned numbers. They are exactly the multiset of keys written to the leaves for that set, duplicates included. A run is the keys written to one leaf up to and including the one written with `in_end` = 1, and each run holds at least one key.
- R3: `out_last` is 1 on exactly one output key per merged set: the final key of the set.
- R4: No key leaves the tree while any leaf has not yet received a key of the current set. With one leaf empty, `out_valid` stays 0.
- R5: When one key is written to every leaf of an idle tree at the same clock edge, `out_valid` is still 0 after the first `log2(WAYS)-1` edges that follow. It rises after edge `log2(WAYS)` counted from the write edge.
- R6: With `out_ready` held at 1 and all runs already in the leaves, a set of `n` keys leaves the root on `n` consecutive cycles.
- R7: A leaf accepts a key when `in_valid` and `in_ready` are both 1. `in_ready` falls once the leaf holds `LEAF_DEPTH` unread keys. While `out_valid` is 1 and `out_ready` is 0, `out_key` and `out_last` hold their values. No key is lost or duplicated under backpressure.
- R8: Runs written behind an end marker are not mixed into the current set. The next set is merged on its own after the current set's `last` key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | WAYS | Per-leaf key strobe |
| in_key | input | WAYS*KEY_W | Per-leaf key; leaf j uses bits [j*KEY_W +: KEY_W] |
| in_end | input | WAYS | Per-leaf flag marking the final key of a run |
| in_ready | output | WAYS | Per-leaf space available |
| out_valid | output | 1 | Root key available |
| out_key | output | KEY_W | Root key |
| out_last | output | 1 | Final key of the merged set |
| out_ready | input | 1 | Consumer accepts the root key |

## Verification
A key passes one registered level per cycle. A key written at edge e0 can therefore first appear at the root output after edge e0+log2(WAYS), which is after edge 2 with the defaults. The bench drives and samples at the falling edge. It checks `out_valid` at each falling edge between the write and that edge, and counts root handshakes over the following cycles to confirm that one key leaves per cycle. Every other output is compared against a queue of expected keys and `last` flags built by bench functions. The comparison happens at the falling edge where the bench itself raises `out_ready`, so order and run boundaries are checked without depending on any fixed latency.

// File: rtl/mst_pkg.sv
package mst_pkg;

  // Which child a merge cell forwards in the current cycle.
  typedef enum logic [1:0] {
    PICK_NONE  = 2'd0,
    PICK_LEFT  = 2'd1,
    PICK_RIGHT = 2'd2
  } pick_e;

endpackage

// File: rtl/mst_fifo.sv
// Show-ahead synchronous FIFO. The caller pushes only when not full or
// when popping in the same cycle, and pops only when not empty.
module mst_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop && !empty;
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign dout   = mem[rd_ptr];

  // Storage has no reset so the array maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/mst_cell.sv
// Two-input merge cell: forwards the smaller head into its own buffer,
// tracking which child has finished its current run.
module mst_cell
  import mst_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_valid,
  input  logic [KEY_W-1:0] l_key,
  input  logic             l_last,
  output logic             l_pop,
  input  logic             r_valid,
  input  logic [KEY_W-1:0] r_key,
  input  logic             r_last,
  output logic             r_pop,
  output logic             o_valid,
  output logic [KEY_W-1:0] o_key,
  output logic             o_last,
  input  logic             o_pop
);

  localparam int EW = KEY_W + 1;

  pick_e            pick;
  logic             l_done;
  logic             r_done;
  logic             buf_full;
  logic             buf_empty;
  logic             can_push;
  logic [KEY_W-1:0] sel_key;
  logic             sel_last;
  logic [EW-1:0]    buf_head;

  // A slot freed by the parent in this cycle may be refilled at once.
  assign can_push = !buf_full || o_pop;

  always_comb begin
    pick = PICK_NONE;
    if (l_done) begin
      if (r_valid) pick = PICK_RIGHT;
    end else if (r_done) begin
      if (l_valid) pick = PICK_LEFT;
    end else if (l_valid && r_valid) begin
      pick = (l_key <= r_key) ? PICK_LEFT : PICK_RIGHT;
    end
    if (!can_push) pick = PICK_NONE;
  end

  always_comb begin
    sel_key  = l_key;
    sel_last = l_last && r_done;
    if (pick == PICK_RIGHT) begin
      sel_key  = r_key;
      sel_last = r_last && l_done;
    end
  end

  assign l_pop = (pick == PICK_LEFT);
  assign r_pop = (pick == PICK_RIGHT);

  always_ff @(posedge clk) begin
    if (rst) begin
      l_done <= 1'b0;
      r_done <= 1'b0;
    end else begin
      if (pick == PICK_LEFT && l_last) begin
        if (r_done) r_done <= 1'b0;
        else        l_done <= 1'b1;
      end
      if (pick == PICK_RIGHT && r_last) begin
        if (l_done) l_done <= 1'b0;
        else        r_done <= 1'b1;
      end
    end
  end

  mst_fifo #(
    .W    (EW),
    .DEPTH(DEPTH)
  ) u_buf (
    .clk  (clk),
    .rst  (rst),
    .push (pick != PICK_NONE),
    .din  ({sel_last, sel_key}),
    .pop  (o_pop),
    .dout (buf_head),
    .empty(buf_empty),
    .full (buf_full)
  );

  assign o_valid = !buf_empty;
  assign o_key   = buf_head[KEY_W-1:0];
  assign o_last  = buf_head[KEY_W];

endmodule

// File: rtl/mst_tree.sv
// K-way merge tree. Nodes use heap numbering: node 1 is the root,
// node i has children 2i and 2i+1, nodes WAYS..2*WAYS-1 are leaf FIFOs.
module mst_tree #(
  parameter int KEY_W      = 32,
  parameter int WAYS       = 4,
  parameter int LEAF_DEPTH = 16,
  parameter int CELL_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WAYS-1:0]       in_valid,
  input  logic [WAYS*KEY_W-1:0] in_key,
  input  logic [WAYS-1:0]       in_end,
  output logic [WAYS-1:0]       in_ready,
  output logic                  out_valid,
  output logic [KEY_W-1:0]      out_key,
  output logic                  out_last,
  input  logic                  out_ready
);

  localparam int NODES = 2 * WAYS;
  localparam int EW    = KEY_W + 1;

  logic             nd_valid [1:NODES-1];
  logic [KEY_W-1:0] nd_key   [1:NODES-1];
  logic             nd_last  [1:NODES-1];
  logic             nd_pop   [1:NODES-1];

  for (genvar j = 0; j < WAYS; j++) begin : g_leaf
    logic          full;
    logic          empty;
    logic [EW-1:0] head;

    assign in_ready[j] = !full;

    mst_fifo #(
      .W    (EW),
      .DEPTH(LEAF_DEPTH)
    ) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (in_valid[j] && !full),
      .din  ({in_end[j], in_key[j*KEY_W +: KEY_W]}),
      .pop  (nd_pop[WAYS+j]),
      .dout (head),
      .empty(empty),
      .full (full)
    );

    assign nd_valid[WAYS+j] = !empty;
    assign nd_key[WAYS+j]   = head[KEY_W-1:0];
    assign nd_last[WAYS+j]  = head[KEY_W];
  end

  for (genvar i = 1; i < WAYS; i++) begin : g_cell
    mst_cell #(
      .KEY_W(KEY_W),
      .DEPTH(CELL_DEPTH)
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .l_valid(nd_valid[2*i]),
      .l_key  (nd_key[2*i]),
      .l_last (nd_last[2*i]),
      .l_pop  (nd_pop[2*i]),
      .r_valid(nd_valid[2*i+1]),
      .r_key  (nd_key[2*i+1]),
      .r_last (nd_last[2*i+1]),
      .r_pop  (nd_pop[2*i+1]),
      .o_valid(nd_valid[i]),
      .o_key  (nd_key[i]),
      .o_last (nd_last[i]),
      .o_pop  (nd_pop[i])
    );
  end

  assign nd_pop[1]  = nd_valid[1] && out_ready;
  assign out_valid  = nd_valid[1];
  assign out_key    = nd_key[1];
  assign out_last   = nd_last[1];

endmodule

// File: rtl/mst_tree_chk.sv
module mst_tree_chk #(
  parameter int KEY_W      = 32,
  parameter int WAYS       = 4,
  parameter int LEAF_DEPTH = 16,
  parameter int CELL_DEPTH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [WAYS-1:0]  in_valid,
  input logic [WAYS-1:0]  in_end,
  input logic [WAYS-1:0]  in_ready,
  input logic             out_valid,
  input logic [KEY_W-1:0] out_key,
  input logic             out_last,
  input logic             out_ready
);

  localparam int CAP = WAYS * LEAF_DEPTH + (WAYS - 1) * CELL_DEPTH;

  logic             out_fire;
  logic [31:0]      acc_now;
  logic [31:0]      end_now;
  logic [31:0]      held;
  logic [31:0]      ends_in;
  logic [31:0]      lasts_out;
  logic             mid;
  logic [KEY_W-1:0] prev_key;

  assign out_fire = out_valid && out_ready;
  assign acc_now  = 32'($countones(in_valid & in_ready));
  assign end_now  = 32'($countones(in_valid & in_ready & in_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= '0;
      ends_in   <= '0;
      lasts_out <= '0;
      mid       <= 1'b0;
      prev_key  <= '0;
    end else begin
      held    <= held + acc_now - (out_fire ? 32'd1 : 32'd0);
      ends_in <= ends_in + end_now;
      if (out_fire) begin
        prev_key <= out_key;
        mid      <= !out_last;
        if (out_last) lasts_out <= lasts_out + 32'd1;
      end
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && (&in_ready))); // R1

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (held != 32'd0)); // R2

  AST_RUN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_fire && mid) |-> (out_key >= prev_key)); // R2

  AST_LAST_MATCH: assert property (@(posedge clk) disable iff (rst)
    (out_fire && out_last) |-> (ends_in >= 32'(WAYS) * (lasts_out + 32'd1))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    held <= 32'(CAP)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_last))); // R7

endmodule

bind mst_tree mst_tree_chk #(
  .KEY_W     (KEY_W),
  .WAYS      (WAYS),
  .LEAF_DEPTH(LEAF_DEPTH),
  .CELL_DEPTH(CELL_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_end   (in_end),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_key  (out_key),
  .out_last (out_last),
  .out_ready(out_ready)
);

// File: tb/mst_tree_tb.sv
module mst_tree_tb;

  localparam int KEY_W      = 32;
  localparam int WAYS       = 4;
  localparam int LEAF_DEPTH = 16;
  localparam int CELL_DEPTH = 2;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [WAYS-1:0]       in_valid = '0;
  logic [WAYS*KEY_W-1:0] in_key = '0;
  logic [WAYS-1:0]       in_end = '0;
  logic [WAYS-1:0]       in_ready;
  logic                  out_valid;
  logic [KEY_W-1:0]      out_key;
  logic                  out_last;
  logic                  out_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mst_tree #(
    .KEY_W(KEY_W), .WAYS(WAYS), .LEAF_DEPTH(LEAF_DEPTH), .CELL_DEPTH(CELL_DEPTH)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key), .in_end(in_end),
    .in_ready(in_ready), .out_valid(out_valid), .out_key(out_key),
    .out_last(out_last), .out_ready(out_ready)
  );

  int unsigned lkey [WAYS][$];
  bit          lend [WAYS][$];
  int unsigned expk [$];
  bit          expl [$];
  bit [WAYS-1:0] lf_fire = '0;
  bit [WAYS-1:0] leaf_en = '1;
  int p_in = 100;
  int p_out = 100;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ofires = 0;
  bit timeout = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pending();
    for (int j = 0; j < WAYS; j++) if (lkey[j].size() != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic push_leaf(input int j, input int unsigned k, input bit e);
    lkey[j].push_back(k);
    lend[j].push_back(e);
  endtask

  task automatic expect_set(input int unsigned ks[$]);
    int unsigned s[$];
    s = ks;
    s.sort();
    for (int i = 0; i < s.size(); i++) begin
      expk.push_back(s[i]);
      expl.push_back(i == s.size() - 1);
    end
  endtask

  task automatic add_random_set(input int maxlen, input bit narrow);
    int unsigned all[$];
    for (int j = 0; j < WAYS; j++) begin
      int unsigned run[$];
      int len;
      len = 1 + int'($urandom % maxlen);
      for (int i = 0; i < len; i++) run.push_back(narrow ? ($urandom % 64) : $urandom);
      run.sort();
      for (int i = 0; i < len; i++) begin
        push_leaf(j, run[i], i == len - 1);
        all.push_back(run[i]);
      end
    end
    expect_set(all);
  endtask

  task automatic check_out();
    if (expk.size() == 0) begin
      chk(1'b0, "R2 unexpected key", longint'(out_key), -1);
    end else begin
      int unsigned ek;
      bit el;
      ek = expk.pop_front();
      el = expl.pop_front();
      chk(out_key == ek, "R2 key order", longint'(out_key), longint'(ek));
      chk(out_last == el, "R3 last flag", longint'(out_last), longint'(el));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc >= WATCHDOG) timeout = 1'b1;
    for (int j = 0; j < WAYS; j++) begin
      if (lf_fire[j]) begin
        void'(lkey[j].pop_front());
        void'(lend[j].pop_front());
      end
    end
    for (int j = 0; j < WAYS; j++) begin
      lf_fire[j]  = 1'b0;
      in_valid[j] = 1'b0;
      if (leaf_en[j] && lkey[j].size() != 0 && int'($urandom % 100) < p_in) begin
        in_valid[j] = 1'b1;
        in_key[j*KEY_W +: KEY_W] = lkey[j][0];
        in_end[j] = lend[j][0];
        lf_fire[j] = in_ready[j];
      end
    end
    out_ready = (int'($urandom % 100) < p_out);
    if (out_valid && out_ready) begin
      ofires++;
      check_out();
    end
  endtask

  task automatic drain();
    while (!timeout && (expk.size() != 0 || pending())) tick();
    repeat (3) tick();
  endtask

  initial begin
    int o0;
    int unsigned ks[$];
    logic [KEY_W-1:0] held_key;
    void'($urandom(32'h1234_abcd));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready", longint'(in_ready), longint'({WAYS{1'b1}}));

    // R5 and R6: one key per leaf in one cycle, then continuous output
    p_in = 100; p_out = 100;
    push_leaf(0, 40, 1); push_leaf(1, 10, 1); push_leaf(2, 30, 1); push_leaf(3, 20, 1);
    ks = '{40, 10, 30, 20};
    expect_set(ks);
    tick();                       // write edge e0 follows
    tick();                       // after e0
    chk(out_valid == 1'b0, "R5 not yet after e0", longint'(out_valid), 0);
    o0 = ofires;
    tick();                       // after e1
    chk(out_valid == 1'b0, "R5 not yet after e1", longint'(out_valid), 0);
    tick();                       // after e2
    chk(out_valid == 1'b1, "R5 valid after e2", longint'(out_valid), 1);
    repeat (3) tick();
    chk(ofires - o0 == 4, "R6 consecutive keys", longint'(ofires - o0), 4);
    drain();

    // R4 and R7: only leaf 0 fed while output stalled
    leaf_en = 4'b0001; p_out = 0;
    ks.delete();
    for (int i = 1; i <= LEAF_DEPTH; i++) begin
      push_leaf(0, i, i == LEAF_DEPTH);
      ks.push_back(i);
    end
    for (int j = 1; j < WAYS; j++) begin
      push_leaf(j, 200 + j, 1);
      ks.push_back(200 + j);
    end
    expect_set(ks);
    repeat (24) tick();
    chk(in_ready[0] == 1'b0, "R7 leaf full", longint'(in_ready[0]), 0);
    chk(out_valid == 1'b0, "R4 one leaf only", longint'(out_valid), 0);
    leaf_en = 4'b0111;
    repeat (10) tick();
    chk(out_valid == 1'b0, "R4 leaf 3 still empty", longint'(out_valid), 0);
    leaf_en = 4'b1111;
    repeat (10) tick();
    chk(out_valid == 1'b1, "R7 root holds key", longint'(out_valid), 1);
    held_key = out_key;
    repeat (5) tick();
    chk(out_key == held_key, "R7 stable under stall", longint'(out_key), longint'(held_key));
    chk(out_key == 1, "R7 smallest key waits", longint'(out_key), 1);
    p_out = 60;
    drain();

    // R8: two sets queued back to back, second smaller than first
    p_in = 100; p_out = 100;
    ks.delete();
    for (int j = 0; j < WAYS; j++) begin
      push_leaf(j, 100 + 2*j, 0); push_leaf(j, 101 + 2*j, 1);
      ks.push_back(100 + 2*j); ks.push_back(101 + 2*j);
    end
    expect_set(ks);
    ks.delete();
    for (int j = 0; j < WAYS; j++) begin
      push_leaf(j, j, 1);
      ks.push_back(j);
    end
    expect_set(ks);
    drain();

    // R2, R3, R7, R8: random sets with duplicates and random handshakes
    for (int g = 0; g < 6; g++) begin
      p_in  = 40 + 12 * g;
      p_out = 100 - 12 * g;
      for (int b = 0; b < 5; b++) add_random_set(1 + (g % 3) * 4, b[0]);
      drain();
    end

    chk(expk.size() == 0, "R2 all keys delivered", longint'(expk.size()), 0);
    chk(out_valid == 1'b0, "R2 no extra keys", longint'(out_valid), 0);
    if (timeout) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule